// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block collects single-cycle event pulses from seven peripheral sources into a flag register and gates them through an enable register. Both registers sit behind a byte-wide register port. The host clears pending flags by writing a mask to the flag register. It changes the enables with one write: bit 7 of the data says whether the bits given in [6:0] are turned on or turned off.

One interrupt line is driven while a flag in the shift, timer-two or timer-one position is both pending and enabled. Reading the flag register returns a summary in bit 7 that covers every enabled flag. Reading the enable register always shows bit 7 high.

Neighbouring blocks can drop flags as a side effect of their own accesses. A read of the shift data offset clears the three shift-related flags. A clear mask port lets any other block retire the flags it owns.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag and enable registers are 0, the interrupt output is low, a flag read (offset 0xD) returns 0x00 and an enable read (offset 0xE) returns 0x80.
- R2: A pulse on source bit i sets flag bit i from the next clock edge on, and the flag then holds with no further pulse.
- R3: A write to offset 0xD clears each flag bit whose data bit is 1 and leaves the other flag bits unchanged.
- R4: A write to offset 0xE with data bit 7 = 1 sets each enable bit given by a 1 in data [6:0] and keeps the rest.
- R5: A write to offset 0xE with data bit 7 = 0 clears each enable bit given by a 1 in data [6:0] and keeps the rest.
- R6: A flag read returns the flags in bits [6:0], and bit 7 is 1 exactly when some flag bit in [6:0] is also enabled.
- R7: An enable read returns the enables in bits [6:0] with bit 7 always 1.
- R8: The interrupt output is high exactly when (flags & enables) has bit 2 (shift), bit 5 (timer two) or bit 6 (timer one) set. Enabled pending flags at bits 0, 1, 3 and 4 do not raise it.
- R9: A read at offset 0xA clears flag bits 2, 3 and 4 (shift, shift data, shift clock).
- R10: A 1 on bit i of the external clear input clears flag bit i at the next edge.
- R11: When a set pulse and any clear request hit the same flag bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data; combinational from the addressed register |
| src_set | input | 7 | One-cycle set pulses, one per flag bit |
| ext_clr | input | 7 | Clear requests from other blocks, one per flag bit |
| irq | output | 1 | Interrupt request |

## Verification
Every register update lands on the clock edge that ends the stimulus cycle. Read data and the interrupt line follow the registers through logic only, so each result is due one edge after its stimulus. The bench drives inputs on the falling edge and removes them on the next falling edge, so exactly one rising edge falls in between. It then checks read data and the interrupt line in that low phase, with no further edge. Flag and enable reads have no side effect, so they can observe state between operations. The shift data read is applied for exactly one edge, like any other stimulus.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    localparam int NSRC   = 7;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] OFS_SHIFT = 4'hA;
    localparam logic [ADDR_W-1:0] OFS_FLAG  = 4'hD;
    localparam logic [ADDR_W-1:0] OFS_EN    = 4'hE;

    localparam logic [NSRC-1:0] IRQ_MASK       = 7'h64;
    localparam logic [NSRC-1:0] SHIFT_CLR_MASK = 7'h1C;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic logic any_pending(input logic [NSRC-1:0] f,
                                         input logic [NSRC-1:0] e);
        return |(f & e);
    endfunction
endpackage

// File: rtl/irq_flag_bits.sv
module irq_flag_bits #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           flag_q[i] <= 1'b0;
            else if (set_i[i]) flag_q[i] <= 1'b1;
            else if (clr_i[i]) flag_q[i] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flag_q[i]); // R11
        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !flag_q[i]); // R3
        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (flag_q[i] && !clr_i[i]) |=> flag_q[i]); // R2
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic         set_mode,
    input  logic [N-1:0] sel,
    output logic [N-1:0] en_o
);
    logic [N-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst)          en_q <= '0;
        else if (we) begin
            if (set_mode) en_q <= en_q | sel;
            else          en_q <= en_q & ~sel;
        end
    end

    assign en_o = en_q;

    AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
        (we && set_mode) |=> ((en_q & $past(sel)) == $past(sel))); // R4
    AST_EN_CLR: assert property (@(posedge clk) disable iff (rst)
        (we && !set_mode) |=> ((en_q & $past(sel)) == '0)); // R5
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_flag_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [NSRC-1:0]   flags,
    input  logic [NSRC-1:0]   ens,
    output logic [DATA_W-1:0] rdata,
    output logic              pending
);
    always_comb begin
        pending = any_pending(flags, ens);
        unique case (addr)
            OFS_FLAG: rdata = {pending, flags};
            OFS_EN:   rdata = {1'b1, ens};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NSRC-1:0]   src_set,
    input  logic [NSRC-1:0]   ext_clr,
    output logic              irq
);
    bus_req_t         req;
    logic [NSRC-1:0]  host_clr;
    logic [NSRC-1:0]  side_clr;
    logic [NSRC-1:0]  clr_all;
    logic [NSRC-1:0]  flags;
    logic [NSRC-1:0]  ens;
    logic             en_we;
    logic             pending;

    assign req = '{wr: reg_wr, rd: reg_rd, addr: reg_addr, data: reg_wdata};

    always_comb begin
        host_clr = (req.wr && req.addr == OFS_FLAG) ? req.data[NSRC-1:0] : '0;
        side_clr = (req.rd && req.addr == OFS_SHIFT) ? SHIFT_CLR_MASK : '0;
        clr_all  = host_clr | side_clr | ext_clr;
        en_we    = req.wr && (req.addr == OFS_EN);
    end

    irq_flag_bits #(.N(NSRC)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (src_set),
        .clr_i  (clr_all),
        .flag_o (flags)
    );

    irq_enable_reg #(.N(NSRC)) u_en (
        .clk      (clk),
        .rst      (rst),
        .we       (en_we),
        .set_mode (req.data[DATA_W-1]),
        .sel      (req.data[NSRC-1:0]),
        .en_o     (ens)
    );

    irq_read_mux u_rd (
        .addr    (req.addr),
        .flags   (flags),
        .ens     (ens),
        .rdata   (reg_rdata),
        .pending (pending)
    );

    assign irq = |(flags & ens & IRQ_MASK);

    AST_IRQ_IMPLIES_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        irq |-> pending); // R8
    AST_EN_READ_TOP: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_EN) |-> reg_rdata[DATA_W-1]); // R7
    AST_SHIFT_READ_CLR: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == OFS_SHIFT && !src_set[2]) |=> !flags[2]); // R9
    AST_EXT_CLR: assert property (@(posedge clk) disable iff (rst)
        (ext_clr[6] && !src_set[6]) |=> !flags[6]); // R10
endmodule

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;
    // {set[6:0], wr, addr[3:0], wdata[7:0], exp_flag[7:0], exp_en[7:0], exp_irq}
    localparam logic [36:0] VEC [NV] = '{
        {7'h44, 1'b0, 4'h0, 8'h00, 8'h44, 8'h80, 1'b0},  // R2
        {7'h00, 1'b1, 4'hE, 8'hC0, 8'hC4, 8'hC0, 1'b1},  // R4 R8
        {7'h00, 1'b1, 4'hE, 8'h88, 8'hC4, 8'hC8, 1'b1},  // R4
        {7'h00, 1'b1, 4'hD, 8'h40, 8'h04, 8'hC8, 1'b0},  // R3
        {7'h08, 1'b0, 4'h0, 8'h00, 8'h8C, 8'hC8, 1'b0},  // R6 R8
        {7'h00, 1'b1, 4'hE, 8'h08, 8'h0C, 8'hC0, 1'b0},  // R5
        {7'h20, 1'b0, 4'h0, 8'h00, 8'h2C, 8'hC0, 1'b0},  // R2
        {7'h00, 1'b1, 4'hE, 8'hA0, 8'hAC, 8'hE0, 1'b1},  // R4 R8
        {7'h00, 1'b1, 4'hD, 8'hFF, 8'h00, 8'hE0, 1'b0},  // R3
        {7'h00, 1'b1, 4'hE, 8'h7F, 8'h00, 8'h80, 1'b0}   // R5 R7
    };

    logic clk = 1'b0;
    logic rst;
    logic reg_wr, reg_rd;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [6:0] src_set, ext_clr;
    logic irq;
    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_flag_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .src_set(src_set), .ext_clr(ext_clr), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic [3:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
        reg_addr = 4'h0;
    endtask

    task automatic cycle(input logic [6:0] s, input logic w, input logic r,
                         input logic [3:0] a, input logic [7:0] d, input logic [6:0] c);
        @(negedge clk);
        src_set = s; reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; ext_clr = c;
        @(negedge clk);
        src_set = '0; reg_wr = 0; reg_rd = 0; reg_addr = 4'h0; reg_wdata = '0; ext_clr = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst = 1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        src_set = 0; ext_clr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        read_reg(4'hD, v); check("R1 flag", v, 8'h00);
        read_reg(4'hE, v); check("R1 enable", v, 8'h80);
        check("R1 irq", {7'h0, irq}, 8'h00);

        for (int k = 0; k < NV; k++) begin
            cycle(VEC[k][36:30], VEC[k][29], 1'b0, VEC[k][28:25], VEC[k][24:17], 7'h00);
            read_reg(4'hD, v); check("R6 vector flag", v, VEC[k][16:9]);
            read_reg(4'hE, v); check("R7 vector enable", v, VEC[k][8:1]);
            check("R8 vector irq", {7'h0, irq}, {7'h0, VEC[k][0]});
        end

        // R2 flag holds across idle cycles
        cycle(7'h01, 0, 0, 4'h0, 8'h00, 7'h00);
        repeat (3) @(negedge clk);
        read_reg(4'hD, v); check("R2 hold", v, 8'h01);

        // R9 shift data read clears bits 2..4 only
        cycle(7'h1C, 0, 0, 4'h0, 8'h00, 7'h00);
        read_reg(4'hD, v); check("R9 before", v, 8'h1D);
        cycle(7'h00, 0, 1, 4'hA, 8'h00, 7'h00);
        read_reg(4'hD, v); check("R9 after", v, 8'h01);

        // R10 external clear
        cycle(7'h7E, 0, 0, 4'h0, 8'h00, 7'h00);
        cycle(7'h00, 0, 0, 4'h0, 8'h00, 7'h60);
        read_reg(4'hD, v); check("R10 ext clear", v, 8'h1F);

        // R11 set wins over host write clear and over external clear
        cycle(7'h01, 1, 0, 4'hD, 8'h01, 7'h00);
        read_reg(4'hD, v); check("R11 vs host clear", v, 8'h1F);
        cycle(7'h02, 0, 0, 4'h0, 8'h00, 7'h02);
        read_reg(4'hD, v); check("R11 vs ext clear", v, 8'h1F);

        // R8 enabled bit 4 raises summary but not irq
        cycle(7'h00, 1, 0, 4'hE, 8'h90, 7'h00);
        read_reg(4'hD, v); check("R6 summary bit4", v, 8'h9F);
        check("R8 no irq bit4", {7'h0, irq}, 8'h00);
        cycle(7'h00, 1, 0, 4'hE, 8'h84, 7'h00);
        check("R8 irq bit2", {7'h0, irq}, 8'h01);
        cycle(7'h00, 1, 0, 4'hD, 8'h04, 7'h00);
        check("R8 irq drops", {7'h0, irq}, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule